// File: doc/BRIEF.md
# Fast GPIO Register Block

This block is a bank of sixteen general-purpose pins that can be taken over, one pin at a time, by a fast register path on a simple 16-bit peripheral bus. Each pin has three control bits. An ownership bit chooses whether the pin is driven by this block or by a separate normal GPIO path. A direction bit chooses input or output. A data bit holds the output level.

When a pin is owned by the block and set as an output, it drives its stored data bit. When it is owned and set as an input, a read of the data register returns the level sampled on the pin through a synchronizer. The data register can be changed in one bus write by a direct load, by a write-zero-to-clear alias, by a write-one-to-set alias, or by a write-one-to-toggle alias. None of these needs a read-modify-write sequence.

The normal GPIO path appears only as plain ports. Its output and output-enable pass through to pins it owns. It sees the pin level only on those pins.

Top module: `fastio_bank`

## Requirements
- R1: After reset, the direction, data and ownership registers all read 0, every `pin_out`/`pin_oe` bit follows `gp_out`/`gp_oe`, and `gp_in` equals `pin_in`.
- R2: A write at byte offset 0x2 loads `bus_wdata` into the data register. For a pin whose direction bit is 1, a read at 0x2 returns the stored bit.
- R3: The direction register at offset 0x0 and the ownership register at offset 0x4 are read/write. Direction bit 1 means output, ownership bit 1 means the block owns the pin.
- R4: A write at offset 0x6 clears each data bit whose `bus_wdata` bit is 0 and leaves each data bit whose `bus_wdata` bit is 1 unchanged.
- R5: A write at offset 0xA sets each data bit whose `bus_wdata` bit is 1. The other data bits are unchanged.
- R6: A write at offset 0xE inverts each data bit whose `bus_wdata` bit is 1. The other data bits are unchanged.
- R7: Reads at offsets 0x6, 0xA and 0xE return the same value as a read at 0x2. No read changes any register.
- R8: For a pin whose ownership bit is 1, `pin_out` carries its data bit and `pin_oe` carries its direction bit. For a pin whose ownership bit is 0, `pin_out` and `pin_oe` carry `gp_out` and `gp_oe`.
- R9: For a pin whose direction bit is 0, a read at 0x2 returns `pin_in` delayed by exactly two rising clock edges.
- R10: Offsets 0x8 and 0xC, and all odd offsets, read as 0, and writes to them change no register.
- R11: A register write becomes visible on the rising edge that ends the cycle in which `bus_sel` and `bus_wr` are both high, and not before that edge.
- R12: `gp_in` carries `pin_in` for pins with ownership bit 0 and reads 0 for pins with ownership bit 1.
- R13: Data-register writes update the stored bits whatever the ownership bits are. The pins show those bits once ownership is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while a read is strobed, else 0 |
| pin_in | input | 16 | Level seen on the package pins |
| pin_out | output | 16 | Level driven onto the package pins |
| pin_oe | output | 16 | Pin output enable |
| gp_out | input | 16 | Normal GPIO path output level |
| gp_oe | input | 16 | Normal GPIO path output enable |
| gp_in | output | 16 | Pin levels handed to the normal GPIO path |

## Verification
The properties assume one bus access per cycle. `bus_wr` is only meaningful while `bus_sel` is high, and `bus_addr` stays steady through the strobed cycle. The stimulus changes every bus input one time unit after a rising edge and drops the strobe after a single cycle, so each write is seen by exactly one edge. Pin inputs change only away from the edge, so the two-edge synchronizer latency can be counted exactly.

// File: rtl/fastio_pkg.sv
package fastio_pkg;

   // Byte offsets in the register window; the alias offsets decide the write action.
   localparam logic [3:0] OFS_DIR  = 4'h0;
   localparam logic [3:0] OFS_DATA = 4'h2;
   localparam logic [3:0] OFS_OWN  = 4'h4;
   localparam logic [3:0] OFS_CLR  = 4'h6;
   localparam logic [3:0] OFS_SET  = 4'hA;
   localparam logic [3:0] OFS_TOG  = 4'hE;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_DIR,
      TGT_DATA,
      TGT_OWN,
      TGT_CLR,
      TGT_SET,
      TGT_TOG
   } fastio_tgt_e;

endpackage

// File: rtl/fastio_decode.sv
module fastio_decode
   import fastio_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic [AW-1:0] addr,
   output fastio_tgt_e   tgt
);

   logic hi_zero;

   generate
      if (AW > 4) begin : g_hi
         assign hi_zero = (addr[AW-1:4] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      tgt = TGT_NONE;
      unique case (addr[3:0])
         OFS_DIR:  tgt = TGT_DIR;
         OFS_DATA: tgt = TGT_DATA;
         OFS_OWN:  tgt = TGT_OWN;
         OFS_CLR:  tgt = TGT_CLR;
         OFS_SET:  tgt = TGT_SET;
         OFS_TOG:  tgt = TGT_TOG;
         default:  tgt = TGT_NONE;
      endcase
      if (!hi_zero) tgt = TGT_NONE;
   end

endmodule

// File: rtl/fastio_sync.sv
module fastio_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/fastio_pinmux.sv
module fastio_pinmux #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] own,
   input  logic [WIDTH-1:0] fast_out,
   input  logic [WIDTH-1:0] fast_oe,
   input  logic [WIDTH-1:0] gp_out,
   input  logic [WIDTH-1:0] gp_oe,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] gp_in
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         assign pin_out[i] = own[i] ? fast_out[i] : gp_out[i];
         assign pin_oe[i]  = own[i] ? fast_oe[i]  : gp_oe[i];
         assign gp_in[i]   = own[i] ? 1'b0        : pin_in[i];
      end
   endgenerate

endmodule

// File: rtl/fastio_bank.sv
module fastio_bank
   import fastio_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   input  logic [WIDTH-1:0] gp_out,
   input  logic [WIDTH-1:0] gp_oe,
   output logic [WIDTH-1:0] gp_in
);

   generate
      if (AW < 4) begin : g_bad_aw
         $error("fastio_bank: AW must cover the 4-bit register window");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fastio_bank: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fastio_bank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] own_q;
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] data_view;
   fastio_tgt_e      tgt;
   logic             wr_go;
   logic             rd_go;

   assign wr_go = bus_sel & bus_wr;
   assign rd_go = bus_sel & ~bus_wr;

   fastio_decode #(.AW(AW)) u_decode (
      .addr (bus_addr),
      .tgt  (tgt)
   );

   fastio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   // Register updates: one write action per cycle, chosen by the offset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
         own_q  <= '0;
      end else if (wr_go) begin
         unique case (tgt)
            TGT_DIR:  dir_q  <= bus_wdata;
            TGT_DATA: data_q <= bus_wdata;
            TGT_OWN:  own_q  <= bus_wdata;
            TGT_CLR:  data_q <= data_q & bus_wdata;
            TGT_SET:  data_q <= data_q | bus_wdata;
            TGT_TOG:  data_q <= data_q ^ bus_wdata;
            default:  ;
         endcase
      end
   end

   // Outputs read back the stored bit, inputs the synchronized pin level.
   assign data_view = (dir_q & data_q) | (~dir_q & pin_sync);

   always_comb begin
      bus_rdata = '0;
      if (rd_go) begin
         unique case (tgt)
            TGT_DIR:                            bus_rdata = dir_q;
            TGT_OWN:                            bus_rdata = own_q;
            TGT_DATA, TGT_CLR, TGT_SET, TGT_TOG: bus_rdata = data_view;
            default:                            bus_rdata = '0;
         endcase
      end
   end

   fastio_pinmux #(.WIDTH(WIDTH)) u_pinmux (
      .own      (own_q),
      .fast_out (data_q),
      .fast_oe  (dir_q),
      .gp_out   (gp_out),
      .gp_oe    (gp_oe),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .gp_in    (gp_in)
   );

endmodule

// File: rtl/fastio_bank_chk.sv
module fastio_bank_chk
   import fastio_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int AW    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] gp_out,
   input logic [WIDTH-1:0] gp_oe,
   input logic [WIDTH-1:0] gp_in,
   input logic [WIDTH-1:0] dir_q,
   input logic [WIDTH-1:0] data_q,
   input logic [WIDTH-1:0] own_q
);

   logic wr_data, wr_clr, wr_set, wr_tog, mapped, rd_any;

   assign wr_data = bus_sel && bus_wr && (bus_addr == AW'(OFS_DATA));
   assign wr_clr  = bus_sel && bus_wr && (bus_addr == AW'(OFS_CLR));
   assign wr_set  = bus_sel && bus_wr && (bus_addr == AW'(OFS_SET));
   assign wr_tog  = bus_sel && bus_wr && (bus_addr == AW'(OFS_TOG));
   assign rd_any  = bus_sel && !bus_wr;
   assign mapped  = (bus_addr == AW'(OFS_DIR)) || (bus_addr == AW'(OFS_DATA)) ||
                    (bus_addr == AW'(OFS_OWN)) || (bus_addr == AW'(OFS_CLR))  ||
                    (bus_addr == AW'(OFS_SET)) || (bus_addr == AW'(OFS_TOG));

   p_direct_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> data_q == $past(bus_wdata));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> data_q == ($past(data_q) & $past(bus_wdata)));

   p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> data_q == ($past(data_q) | $past(bus_wdata)));

   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tog |=> data_q == ($past(data_q) ^ $past(bus_wdata)));

   p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> $stable(data_q) && $stable(dir_q) && $stable(own_q));

   p_fast_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ data_q) | (pin_oe ^ dir_q)) & own_q) == '0);

   p_normal_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ gp_out) | (pin_oe ^ gp_oe)) & ~own_q) == '0);

   p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !mapped) |=>
         $stable(data_q) && $stable(dir_q) && $stable(own_q));

   p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && !mapped) |-> bus_rdata == '0);

   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |-> bus_rdata == '0);

   p_gp_in_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_in & own_q) == '0);

endmodule

bind fastio_bank fastio_bank_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .gp_out    (gp_out),
   .gp_oe     (gp_oe),
   .gp_in     (gp_in),
   .dir_q     (dir_q),
   .data_q    (data_q),
   .own_q     (own_q)
);

// File: tb/fastio_bank_tb.sv
`timescale 1ns/1ps
module fastio_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic [15:0] gp_out = 16'h1234;
   logic [15:0] gp_oe  = 16'h00FF;
   logic [15:0] gp_in;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   fastio_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .gp_out(gp_out), .gp_oe(gp_oe), .gp_in(gp_in)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected read value per strobed read cycle.
   always @(negedge clk) begin
      if (rst_n && bus_sel && !bus_wr) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R7 unexpected read actual=%h expected=none", bus_rdata);
         end else begin
            chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      chk(pin_out, gp_out, "R1 pin_out follows normal path");
      chk(pin_oe, gp_oe, "R1 pin_oe follows normal path");
      chk(gp_in, pin_in, "R1 gp_in");
      rd(4'h0, 16'h0000, "R1 dir reset");
      rd(4'h4, 16'h0000, "R1 own reset");
      rd(4'h2, 16'h0000, "R1 data reset");
      idle();

      wr(4'h0, 16'hFFFF);
      rd(4'h0, 16'hFFFF, "R3 dir readback");
      wr(4'h4, 16'hA5C3);
      rd(4'h4, 16'hA5C3, "R3 own readback");
      wr(4'h4, 16'h0000);

      wr(4'h2, 16'h1357);
      rd(4'h2, 16'h1357, "R2 data readback");
      idle();
      chk(pin_out, gp_out, "R13 data written while unowned not on pins");
      wr(4'h4, 16'hFFFF);
      #2 chk(pin_out, 16'h1357, "R13 data appears once owned");

      // R11: value changes only at the edge ending the write cycle
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h2; bus_wdata = 16'hBEEF;
      #5 chk(pin_out, 16'h1357, "R11 before edge");
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
      chk(pin_out, 16'hBEEF, "R11 after edge");

      chk(pin_oe, 16'hFFFF, "R8 owned oe");
      wr(4'h4, 16'h00FF);
      wr(4'h0, 16'h0F0F);
      #2;
      chk(pin_out, (16'hBEEF & 16'h00FF) | (gp_out & 16'hFF00), "R8 mixed out");
      chk(pin_oe, 16'h000F, "R8 mixed oe");
      wr(4'h0, 16'hFFFF);

      wr(4'h6, 16'hFF0F);
      rd(4'h2, 16'hBE0F, "R4 clear alias");
      rd(4'h6, 16'hBE0F, "R7 read at clear offset");
      wr(4'hA, 16'h0030);
      rd(4'hA, 16'hBE3F, "R5 set alias");
      wr(4'hE, 16'hF001);
      rd(4'hE, 16'h4E3E, "R6 toggle alias");
      rd(4'h2, 16'h4E3E, "R7 repeated read");
      rd(4'h2, 16'h4E3E, "R7 repeated read again");
      rd(4'h4, 16'h00FF, "R7 own unchanged by reads");

      wr(4'h8, 16'hFFFF);
      wr(4'hC, 16'hFFFF);
      wr(4'h3, 16'hFFFF);
      rd(4'h8, 16'h0000, "R10 read 0x8");
      rd(4'hC, 16'h0000, "R10 read 0xC");
      rd(4'h3, 16'h0000, "R10 read odd");
      rd(4'h2, 16'h4E3E, "R10 data untouched");
      rd(4'h0, 16'hFFFF, "R10 dir untouched");
      rd(4'h4, 16'h00FF, "R10 own untouched");

      wr(4'h0, 16'h00FF);
      repeat (3) @(posedge clk);
      rd(4'h2, 16'h003E, "R9 inputs low");
      idle();
      @(posedge clk); #1 pin_in = 16'hA5FF;
      rd(4'h2, 16'h003E, "R9 one edge not yet visible");
      rd(4'h2, 16'hA53E, "R9 visible after two edges");
      idle();

      #2 chk(gp_in, 16'hA500, "R12 owned pins masked");
      wr(4'h4, 16'h0000);
      #2 chk(gp_in, 16'hA5FF, "R12 all pins to normal path");

      idle();
      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R7 reads missing actual=%0d expected=0", exp_q.size());
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule